// File: doc/BRIEF.md
# Wait-stated CRC-32 bus peripheral

This block is a CRC-32 accelerator that sits on an AHB-Lite bus as a slave. Software writes 32-bit words into a data register. Each accepted word is folded into a running checksum over four clock cycles, one byte per cycle, most significant byte first. Reading the data register returns the running checksum. A control register holds a self-clearing restart bit that sets the checksum back to all ones.

Software never polls a status flag. While the engine is occupied, either by a word or by a restart, any transfer that reaches its data phase is held with HREADYOUT low until the engine is free. Back-to-back writes therefore need no pacing. A read issued right after a write returns the updated checksum. A first word written right after a restart is held rather than lost.

The generator polynomial is 0x04C11DB7, processed MSB first. There is no reflection of input or output and no final XOR.

Top module: `crc32_ahb`

## Requirements
- R1: After `hresetn` is released, including a reset applied while a word is being folded, the data register (offset 0x0) reads 0xFFFFFFFF with no wait state.
- R2: Writing a word with bit 0 set to the control register (offset 0x8) sets the running checksum to 0xFFFFFFFF.
- R3: Each word written to offset 0x0 updates the checksum to the value that a bit-serial CRC gives. That CRC uses polynomial 0x04C11DB7, shifts the word in from bit 31 down to bit 0, and applies no reflection and no final XOR.
- R4: An accepted data word occupies the engine for 4 clock edges, starting with the edge that completes the write. A data-register write whose data phase directly follows it sees exactly 3 wait states.
- R5: A data-register read whose data phase directly follows a data write sees exactly 3 wait states and returns the checksum that includes that write.
- R6: A restart occupies the engine for the same 4 edges. A data write issued right after it sees 3 wait states and is folded into the all-ones value.
- R7: The control register always reads back as zero.
- R8: Writes to any offset other than 0x0 and 0x8 change nothing and cause no later wait state. Reads from such offsets return zero.
- R9: A transfer is started by `hsel` high with `htrans` equal to 2'b10 (NONSEQ) or 2'b11 (SEQ). Its data phase completes with no wait state when the engine is idle. `hresp` is always OKAY (0).
- R10: A control-register write with bit 0 clear leaves the checksum unchanged and causes no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte offset within the block |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus-wide ready; an address phase is sampled when high |
| hreadyout | output | 1 | Low while a data phase is being stalled |
| hrdata | output | 32 | Read data (data phase) |
| hresp | output | 1 | Response, always OKAY |

## Verification
The hardest situation to reach is a data phase that lands exactly while the engine is still busy. This happens with a write that follows a restart, a read that follows a write, or a write that follows a write. A bench that drives one transfer at a time never overlaps an address phase with the previous data phase, so it never reaches this state. The bench therefore uses a pipelined driver that puts the next address phase on the bus during the current data phase. It runs sequences of such overlapped transfers and counts the wait states of each one. A behavioural model in the bench tracks the remaining engine occupancy and predicts `hreadyout` on every cycle.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

  // Strobes from the bus control into the checksum datapath
  typedef struct packed {
    logic loadWord;   // fold a new word, first byte on this edge
    logic initCrc;    // restart the checksum at all ones
  } crcStrobeT;

  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] TRANS_SEQ    = 2'b11;

endpackage

// File: rtl/crc32_dp.sv
module crc32_dp
  import crc32_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHUNK_W = 8,
  parameter logic [DATA_W-1:0] POLY = 32'h04C11DB7,
  parameter logic [DATA_W-1:0] INIT = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobeT         strb,
  input  logic [DATA_W-1:0] wordIn,
  output logic              busy,
  output logic [DATA_W-1:0] crcOut
);

  localparam int STEPS = DATA_W / CHUNK_W;
  localparam int CNT_W = $clog2(STEPS) + 1;
  localparam logic [CNT_W-1:0] LAST_REM = CNT_W'(STEPS - 1);

  logic [DATA_W-1:0] crcQ;
  logic [DATA_W-1:0] wordQ;
  logic [CNT_W-1:0]  remQ;
  logic              holdQ;

  function automatic logic [DATA_W-1:0] foldChunk(
    input logic [DATA_W-1:0]  cur,
    input logic [CHUNK_W-1:0] chunk
  );
    logic [DATA_W-1:0] c;
    logic fb;
    c = cur;
    for (int b = CHUNK_W - 1; b >= 0; b--) begin
      fb = c[DATA_W-1] ^ chunk[b];
      c  = {c[DATA_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcQ  <= INIT;
      wordQ <= '0;
      remQ  <= '0;
      holdQ <= 1'b0;
    end else if (strb.initCrc) begin
      crcQ  <= INIT;
      wordQ <= '0;
      remQ  <= LAST_REM;
      holdQ <= 1'b1;
    end else if (strb.loadWord) begin
      crcQ  <= foldChunk(crcQ, wordIn[DATA_W-1 -: CHUNK_W]);
      wordQ <= wordIn << CHUNK_W;
      remQ  <= LAST_REM;
      holdQ <= 1'b0;
    end else if (remQ != '0) begin
      if (!holdQ) crcQ <= foldChunk(crcQ, wordQ[DATA_W-1 -: CHUNK_W]);
      wordQ <= wordQ << CHUNK_W;
      remQ  <= remQ - 1'b1;
    end
  end

  assign busy   = (remQ != '0);
  assign crcOut = crcQ;

  AST_INIT_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    strb.initCrc |=> (crcQ == INIT && busy)) else $error("restart value"); // R2

  AST_LOAD_OCCUPIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWord |=> busy) else $error("load not busy"); // R4

  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadWord || strb.initCrc) |-> !busy) else $error("strobe while busy"); // R4

endmodule

// File: rtl/crc32_ctrl.sv
module crc32_ctrl
  import crc32_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h0,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hready,
  input  logic              ctrlBit,
  input  logic              busy,
  input  logic [DATA_W-1:0] crcIn,
  output crcStrobeT         strb,
  output logic              hreadyout,
  output logic [DATA_W-1:0] hrdata
);

  logic              dpValid;
  logic              dpWrite;
  logic [ADDR_W-1:0] dpAddr;
  logic              hitData;
  logic              hitCtrl;
  logic              accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpValid <= 1'b0;
      dpWrite <= 1'b0;
      dpAddr  <= '0;
    end else if (hready) begin
      dpValid <= hsel && (htrans == TRANS_NONSEQ || htrans == TRANS_SEQ);
      dpWrite <= hwrite;
      dpAddr  <= haddr;
    end
  end

  always_comb begin
    hitData       = (dpAddr == DATA_OFS);
    hitCtrl       = (dpAddr == CTRL_OFS);
    accept        = dpValid && !busy;
    hreadyout     = !(dpValid && busy);
    strb.loadWord = accept && dpWrite && hitData;
    strb.initCrc  = accept && dpWrite && hitCtrl && ctrlBit;
    hrdata        = (accept && !dpWrite && hitData) ? crcIn : '0;
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (dpValid && !hreadyout && !hready) |=> (dpValid && $stable(dpAddr) && $stable(dpWrite)))
    else $error("stalled phase lost"); // R5

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> hreadyout) else $error("wait state while idle"); // R9

endmodule

// File: rtl/crc32_ahb.sv
module crc32_ahb
  import crc32_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [31:0]       hwdata,
  input  logic              hready,
  output logic              hreadyout,
  output logic [31:0]       hrdata,
  output logic              hresp
);

  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(8);

  crcStrobeT         strb;
  logic              busy;
  logic [DATA_W-1:0] crcVal;

  crc32_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS)
  ) uCtrl (
    .clk(hclk), .rstN(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hready(hready), .ctrlBit(hwdata[0]), .busy(busy),
    .crcIn(crcVal), .strb(strb), .hreadyout(hreadyout), .hrdata(hrdata)
  );

  crc32_dp #(
    .DATA_W(DATA_W), .CHUNK_W(8), .POLY(POLY), .INIT('1)
  ) uDp (
    .clk(hclk), .rstN(hresetn), .strb(strb), .wordIn(hwdata),
    .busy(busy), .crcOut(crcVal)
  );

  assign hresp = 1'b0;

endmodule

// File: tb/sim_crc32_ahb.sv
`timescale 1ns/1ps
module sim_crc32_ahb;

  logic        hclk = 1'b0;
  logic        hresetn = 1'b0;
  logic        hsel = 1'b0;
  logic [3:0]  haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [31:0] hwdata = '0;
  logic        hready;
  logic        hreadyout;
  logic [31:0] hrdata;
  logic        hresp;

  always #2.5 hclk = ~hclk;
  assign hready = hreadyout;

  crc32_ahb u0 (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hwdata(hwdata), .hready(hready), .hreadyout(hreadyout),
    .hrdata(hrdata), .hresp(hresp)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] refCrc = 32'hFFFFFFFF;
  int          refLeft = 0;

  logic        opWr   [0:31];
  logic [3:0]  opAddr [0:31];
  logic [31:0] opData [0:31];
  string       opTag  [0:31];
  int          opWait [0:31];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] serialCrc(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      fb = r[31] ^ w[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic void setOp(input int k, input logic wr, input logic [3:0] a,
                                input logic [31:0] d, input string tag);
    opWr[k] = wr; opAddr[k] = a; opData[k] = d; opTag[k] = tag; opWait[k] = 0;
  endfunction

  // Pipelined driver with per-cycle reference model
  task automatic run(input int n);
    int i = 0;
    int pend = -1;
    bit rdy;
    logic [31:0] expRd;
    while (i < n || pend >= 0) begin
      @(negedge hclk);
      if (i < n) begin
        hsel = 1'b1; htrans = 2'b10; haddr = opAddr[i]; hwrite = opWr[i];
      end else begin
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
      end
      hwdata = (pend >= 0) ? opData[pend] : 32'h0;
      #1;
      rdy = hreadyout;
      check(rdy == !(pend >= 0 && refLeft > 0), "R4", {31'b0, rdy},
            {31'b0, !(pend >= 0 && refLeft > 0)}, "hreadyout per cycle");
      check(hresp == 1'b0, "R9", {31'b0, hresp}, 32'h0, "hresp OKAY");
      if (pend >= 0 && !rdy) opWait[pend]++;
      if (pend >= 0 && rdy && !opWr[pend]) begin
        expRd = (opAddr[pend] == 4'h0) ? refCrc : 32'h0;
        check(hrdata == expRd, opTag[pend], hrdata, expRd, "read data");
      end
      @(posedge hclk);
      if (refLeft > 0) refLeft--;
      if (pend >= 0 && rdy && opWr[pend]) begin
        if (opAddr[pend] == 4'h0) begin
          refCrc = serialCrc(refCrc, opData[pend]);
          refLeft = 3;
        end else if (opAddr[pend] == 4'h8 && opData[pend][0]) begin
          refCrc = 32'hFFFFFFFF;
          refLeft = 3;
        end
      end
      if (rdy) begin
        pend = (i < n) ? i : -1;
        if (i < n) i++;
      end
    end
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = '0;
    if (refLeft > 0) refLeft--;
  endtask

  task automatic settle();
    repeat (6) @(posedge hclk);
    refLeft = 0;
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [31:0] saved;
    repeat (3) @(posedge hclk);
    @(negedge hclk);
    hresetn = 1'b1;
    #1;
    check(hreadyout == 1'b1, "R1", {31'b0, hreadyout}, 32'h1, "ready after reset");

    // R1: reset value, no wait
    setOp(0, 0, 4'h0, 0, "R1");
    run(1);
    check(opWait[0] == 0, "R1", opWait[0], 0, "waits on first read");

    // R5: write then read at once
    setOp(0, 1, 4'h0, 32'h12345678, "R3");
    setOp(1, 0, 4'h0, 0, "R5");
    run(2);
    check(opWait[1] == 3, "R5", opWait[1], 3, "read-after-write waits");
    check(serialCrc(32'hFFFFFFFF, 32'h12345678) == refCrc, "R3", refCrc,
          serialCrc(32'hFFFFFFFF, 32'h12345678), "model single word");

    // R4: back-to-back writes of distinct patterns
    setOp(0, 1, 4'h0, 32'h00000000, "R4");
    setOp(1, 1, 4'h0, 32'hFFFFFFFF, "R4");
    setOp(2, 1, 4'h0, 32'hA5A55A5A, "R4");
    setOp(3, 1, 4'h0, 32'h80000001, "R4");
    setOp(4, 0, 4'h0, 0, "R3");
    run(5);
    for (int k = 1; k < 4; k++)
      check(opWait[k] == 3, "R4", opWait[k], 3, "back-to-back write waits");
    check(opWait[4] == 3, "R5", opWait[4], 3, "read after burst waits");

    // R2 / R6: restart then immediate write, then read
    setOp(0, 1, 4'h8, 32'h1, "R2");
    setOp(1, 1, 4'h0, 32'hDEADBEEF, "R6");
    setOp(2, 0, 4'h0, 0, "R6");
    run(3);
    check(opWait[1] == 3, "R6", opWait[1], 3, "write after restart waits");
    check(refCrc == serialCrc(32'hFFFFFFFF, 32'hDEADBEEF), "R6", refCrc,
          serialCrc(32'hFFFFFFFF, 32'hDEADBEEF), "model restart fold");

    // R2: restart then read gives all ones; R7 control reads zero
    setOp(0, 1, 4'h8, 32'h1, "R2");
    setOp(1, 0, 4'h0, 0, "R2");
    setOp(2, 0, 4'h8, 0, "R7");
    run(3);
    check(opWait[1] == 3, "R6", opWait[1], 3, "read after restart waits");
    check(opWait[2] == 0, "R9", opWait[2], 0, "idle read no wait");

    // R8: undefined offsets
    setOp(0, 1, 4'h0, 32'h0F0F0F0F, "R3");
    run(1);
    settle();
    saved = refCrc;
    setOp(0, 1, 4'h4, 32'hFFFFFFFF, "R8");
    setOp(1, 1, 4'hC, 32'h00000001, "R8");
    setOp(2, 0, 4'h0, 0, "R8");
    setOp(3, 0, 4'h4, 0, "R8");
    setOp(4, 0, 4'hC, 0, "R8");
    run(5);
    check(opWait[1] == 0 && opWait[2] == 0, "R8", opWait[1] + opWait[2], 0,
          "no waits after undefined writes");
    check(refCrc == saved, "R8", refCrc, saved, "checksum kept");

    // R10: control write with bit 0 clear
    setOp(0, 1, 4'h8, 32'hFFFFFFFE, "R10");
    setOp(1, 0, 4'h0, 0, "R10");
    run(2);
    check(opWait[1] == 0, "R10", opWait[1], 0, "no wait after clear-bit control write");

    // R3: long back-to-back stream
    lfsr = 32'h1;
    for (int k = 0; k < 20; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]} ^ 32'h9E3779B9;
      setOp(k, 1, 4'h0, lfsr, "R3");
    end
    setOp(20, 0, 4'h0, 0, "R3");
    run(21);
    for (int k = 1; k < 20; k++)
      check(opWait[k] == 3, "R4", opWait[k], 3, "stream write waits");

    // R1: reset during a fold
    setOp(0, 1, 4'h0, 32'hCAFEF00D, "R3");
    run(1);
    hresetn = 1'b0;
    refCrc = 32'hFFFFFFFF;
    refLeft = 0;
    repeat (2) @(posedge hclk);
    @(negedge hclk);
    hresetn = 1'b1;
    setOp(0, 0, 4'h0, 0, "R1");
    run(1);
    check(opWait[0] == 0, "R1", opWait[0], 0, "read after mid-fold reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge hclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule